// File: doc/BRIEF.md
# Trigger-Word Transfer Request Detector

This block snoops CPU writes into the transfer parameter memory and raises a transfer request when a write lands on the trigger word of an entry that one of eight queued channels points at. The memory holds 128 entries of eight 32-bit words each. Every channel owns a mapping register naming a target entry and one of its eight words. Software updates whichever part of an entry it needs and picks the field it rewrites last (a count, say) as the trigger word. That last write then starts the transfer, with no separate start command.

Writes to the other words of an entry only change the context and start nothing. A channel acts only when its bit in the enable register is set. A trigger that cannot be taken sets a sticky per-channel missed flag: either the channel is disabled, or a request for that channel is still waiting. Requests leave on a valid/ready port that carries the channel and the entry latched at trigger time. When several channels are waiting, the lowest-numbered one goes first. The memory itself, the transfer engine and arbitration against other request sources sit outside the block.

Top module: `trigw_top`

## Requirements
- R1: After a synchronous active-low reset, `req_valid` is 0 and every mapping register, the enable register and the missed flags read 0.
- R2: Register index c (0 to 7) is the mapping register of channel c: the trigger word is in bits [4:2] and the entry number in bits [13:5]. Only values 0 to 127 are held there, so bits 13 and 12 and every bit outside [13:2] read 0. Index 8 is the enable register, with bit c enabling channel c and bits above 7 reading 0. Index 9 holds the missed flags, bit c for channel c. Reads are combinational on `reg_rd_addr`.
- R3: A snooped write with `pw_valid` = 1 and at least one byte enable set, whose byte address bits [11:2] equal {entry, word} of an enabled channel that is not waiting, makes that channel wait. From the next cycle on, `req_valid` = 1 with `req_chan` = channel and `req_entry` = entry. Address bits [1:0] are ignored.
- R4: A write to another word of the mapped entry, or to another entry, starts no request.
- R5: A write with all four byte enables at 0 starts no request and sets no missed flag.
- R6: A matching write on a disabled channel starts no request and sets that channel's missed flag.
- R7: A matching write on a channel that is already waiting sets its missed flag and queues no second request. Once the waiting request is accepted, no further request follows.
- R8: While `req_valid` = 1 and `req_ready` = 0, the request stays valid. A handshake (`req_valid` and `req_ready` both 1 at a clock edge) removes the accepted channel from the waiting set at that edge.
- R9: When several channels are waiting, the lowest-numbered one is presented first, then the next, one per handshake.
- R10: Missed flags are sticky and are cleared only by writing 1 to their bit at index 9. A set in the same cycle as a clear leaves the flag at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pw_valid | input | 1 | Snooped parameter-memory write is present |
| pw_addr | input | 12 | Byte address of the snooped write |
| pw_be | input | 4 | Byte enables of the snooped write |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 4 | Register index for the write |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_addr | input | 4 | Register index for the read |
| reg_rd_data | output | 32 | Register read data |
| req_valid | output | 1 | A transfer request is offered |
| req_ready | input | 1 | Downstream takes the request |
| req_chan | output | 3 | Channel of the offered request |
| req_entry | output | 7 | Parameter entry of the offered request |

## Verification
The bound checker watches, on every cycle, that a request can only appear after a write with active byte enables, that an unaccepted request stays up, that the presented channel is always the lowest waiting one, that a disabled channel never starts waiting, and that missed flags drop only on an explicit clear. Only the bench scenarios can show the address decode itself: which word of which entry matches, and that byte-lane offsets are ignored. The same holds for the exact channel and entry values, the register readback layout, the collision and set-over-clear cases, and the full drain order of a three-channel match.

// File: rtl/trigw_pkg.sv
// Package trigw_pkg
// Shared field positions and register indices for the trigger-word detector.
// Assumes the mapping register layout described in the block's brief.
package trigw_pkg;
    localparam int unsigned MAP_WORD_LSB   = 2;   // trigger-word field start
    localparam int unsigned MAP_ENT_LSB    = 5;   // entry field start
    localparam int unsigned MAP_ENT_FIELD  = 9;   // width reserved for entry field
    localparam int unsigned REG_DATA_W     = 32;  // register port width
    localparam int unsigned WORD_BYTES_LG  = 2;   // 32-bit words, byte addressed
endpackage

// File: rtl/trigw_regs.sv
// Module trigw_regs
// Holds per-channel mapping registers, the channel enable register and the
// sticky missed flags; provides combinational readback.
// Assumes index 0..NUM_CH-1 are mapping registers, NUM_CH is enable,
// NUM_CH+1 is the write-1-to-clear missed flag register.
module trigw_regs
    import trigw_pkg::*;
#(
    parameter int unsigned NUM_CH  = 8,
    parameter int unsigned ENT_W   = 7,
    parameter int unsigned WRD_W   = 3,
    parameter int unsigned RADDR_W = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           reg_wr_en,
    input  logic [RADDR_W-1:0]             reg_wr_addr,
    input  logic [REG_DATA_W-1:0]          reg_wr_data,
    input  logic [RADDR_W-1:0]             reg_rd_addr,
    input  logic [NUM_CH-1:0]              missed_set,
    output logic [REG_DATA_W-1:0]          reg_rd_data,
    output logic [NUM_CH-1:0][ENT_W-1:0]   map_entry,
    output logic [NUM_CH-1:0][WRD_W-1:0]   map_word,
    output logic [NUM_CH-1:0]              chan_en,
    output logic [NUM_CH-1:0]              missed
);
    localparam logic [RADDR_W-1:0] EN_IDX   = RADDR_W'(NUM_CH);
    localparam logic [RADDR_W-1:0] MISS_IDX = RADDR_W'(NUM_CH + 1);

    logic [NUM_CH-1:0] miss_clr;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_CH; gi++) begin : g_map
            // Capture entry and trigger-word fields for channel gi.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    map_entry[gi] <= '0;
                    map_word[gi]  <= '0;
                end else if (reg_wr_en && reg_wr_addr == RADDR_W'(gi)) begin
                    map_entry[gi] <= reg_wr_data[MAP_ENT_LSB +: ENT_W];
                    map_word[gi]  <= reg_wr_data[MAP_WORD_LSB +: WRD_W];
                end
            end
        end
    endgenerate

    // Channel enable register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_en <= '0;
        end else if (reg_wr_en && reg_wr_addr == EN_IDX) begin
            chan_en <= reg_wr_data[NUM_CH-1:0];
        end
    end

    // Decode the write-1-to-clear mask for the missed flags.
    always_comb begin
        miss_clr = '0;
        if (reg_wr_en && reg_wr_addr == MISS_IDX) begin
            miss_clr = reg_wr_data[NUM_CH-1:0];
        end
    end

    // Sticky missed flags; a new set wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            missed <= '0;
        end else begin
            missed <= (missed & ~miss_clr) | missed_set;
        end
    end

    // Combinational readback with unused bits at zero.
    always_comb begin
        reg_rd_data = '0;
        if (reg_rd_addr == EN_IDX) begin
            reg_rd_data[NUM_CH-1:0] = chan_en;
        end else if (reg_rd_addr == MISS_IDX) begin
            reg_rd_data[NUM_CH-1:0] = missed;
        end else begin
            for (int k = 0; k < NUM_CH; k++) begin
                if (reg_rd_addr == RADDR_W'(k)) begin
                    reg_rd_data[MAP_ENT_LSB +: ENT_W]  = map_entry[k];
                    reg_rd_data[MAP_WORD_LSB +: WRD_W] = map_word[k];
                end
            end
        end
    end
endmodule

// File: rtl/trigw_match.sv
// Module trigw_match
// Compares each snooped parameter-memory write against every channel's
// mapped entry and trigger word. Purely combinational.
// Assumes byte addressing with 32-bit words: word index = addr[..:2].
module trigw_match
    import trigw_pkg::*;
#(
    parameter int unsigned NUM_CH = 8,
    parameter int unsigned ENT_W  = 7,
    parameter int unsigned WRD_W  = 3,
    parameter int unsigned PW_AW  = 12
) (
    input  logic                         pw_valid,
    input  logic [PW_AW-1:0]             pw_addr,
    input  logic [3:0]                   pw_be,
    input  logic [NUM_CH-1:0][ENT_W-1:0] map_entry,
    input  logic [NUM_CH-1:0][WRD_W-1:0] map_word,
    output logic [NUM_CH-1:0]            hit
);
    localparam int unsigned IDX_W = ENT_W + WRD_W;

    logic             wr_live;
    logic [IDX_W-1:0] wr_index;

    // A write qualifies only when valid with at least one active byte lane.
    always_comb begin
        wr_live  = pw_valid && (pw_be != 4'b0000);
        wr_index = pw_addr[WORD_BYTES_LG +: IDX_W];
    end

    genvar gc;
    generate
        for (gc = 0; gc < NUM_CH; gc++) begin : g_cmp
            // Word-index compare for channel gc.
            always_comb begin
                hit[gc] = wr_live && (wr_index == {map_entry[gc], map_word[gc]});
            end
        end
    endgenerate
endmodule

// File: rtl/trigw_queue.sv
// Module trigw_queue
// Tracks one waiting request per channel, latches the entry at trigger time,
// presents the lowest waiting channel on a valid/ready port and reports
// triggers that could not be taken.
// Assumes hit is already qualified by byte enables and address match.
module trigw_queue #(
    parameter int unsigned NUM_CH = 8,
    parameter int unsigned ENT_W  = 7,
    parameter int unsigned CH_W   = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_CH-1:0]            hit,
    input  logic [NUM_CH-1:0]            chan_en,
    input  logic [NUM_CH-1:0][ENT_W-1:0] map_entry,
    input  logic                         req_ready,
    output logic                         req_valid,
    output logic [CH_W-1:0]              req_chan,
    output logic [ENT_W-1:0]             req_entry,
    output logic [NUM_CH-1:0]            pend,
    output logic [NUM_CH-1:0]            missed_set
);
    logic [NUM_CH-1:0][ENT_W-1:0] ent_q;
    logic [NUM_CH-1:0]            take;
    logic [NUM_CH-1:0]            done;
    logic                         accept;
    logic [CH_W-1:0]              sel;

    // Pick the lowest-numbered waiting channel.
    always_comb begin
        sel = '0;
        for (int k = NUM_CH - 1; k >= 0; k--) begin
            if (pend[k]) begin
                sel = CH_W'(k);
            end
        end
    end

    // Output view of the selected request and handshake decode.
    always_comb begin
        req_valid = |pend;
        req_chan  = sel;
        req_entry = ent_q[sel];
        accept    = req_valid && req_ready;
    end

    genvar gq;
    generate
        for (gq = 0; gq < NUM_CH; gq++) begin : g_slot
            // Classify this channel's trigger: taken, or missed.
            always_comb begin
                take[gq]       = hit[gq] && chan_en[gq] && !pend[gq];
                missed_set[gq] = hit[gq] && (!chan_en[gq] || pend[gq]);
                done[gq]       = accept && (sel == CH_W'(gq));
            end

            // Waiting bit and latched entry for channel gq.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pend[gq]  <= 1'b0;
                    ent_q[gq] <= '0;
                end else begin
                    if (take[gq]) begin
                        pend[gq]  <= 1'b1;
                        ent_q[gq] <= map_entry[gq];
                    end else if (done[gq]) begin
                        pend[gq]  <= 1'b0;
                    end
                end
            end
        end
    endgenerate
endmodule

// File: rtl/trigw_top.sv
// Module trigw_top
// Trigger-word detector for queued transfer channels: snoops parameter
// memory writes, matches them against per-channel mapping registers and
// issues requests. Assumes one snooped write per cycle, byte addressed.
module trigw_top
    import trigw_pkg::*;
#(
    parameter int unsigned NUM_CH    = 8,
    parameter int unsigned NUM_ENT   = 128,
    parameter int unsigned ENT_WORDS = 8,
    localparam int unsigned ENT_W    = $clog2(NUM_ENT),
    localparam int unsigned WRD_W    = $clog2(ENT_WORDS),
    localparam int unsigned CH_W     = $clog2(NUM_CH),
    localparam int unsigned PW_AW    = ENT_W + WRD_W + WORD_BYTES_LG,
    localparam int unsigned RADDR_W  = $clog2(NUM_CH + 2)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  pw_valid,
    input  logic [PW_AW-1:0]      pw_addr,
    input  logic [3:0]            pw_be,
    input  logic                  reg_wr_en,
    input  logic [RADDR_W-1:0]    reg_wr_addr,
    input  logic [REG_DATA_W-1:0] reg_wr_data,
    input  logic [RADDR_W-1:0]    reg_rd_addr,
    output logic [REG_DATA_W-1:0] reg_rd_data,
    output logic                  req_valid,
    input  logic                  req_ready,
    output logic [CH_W-1:0]       req_chan,
    output logic [ENT_W-1:0]      req_entry
);
    logic [NUM_CH-1:0][ENT_W-1:0] map_entry;
    logic [NUM_CH-1:0][WRD_W-1:0] map_word;
    logic [NUM_CH-1:0]            chan_en;
    logic [NUM_CH-1:0]            missed_flags;
    logic [NUM_CH-1:0]            missed_set;
    logic [NUM_CH-1:0]            hit;
    logic [NUM_CH-1:0]            pend_bits;

    trigw_regs #(
        .NUM_CH (NUM_CH),
        .ENT_W  (ENT_W),
        .WRD_W  (WRD_W),
        .RADDR_W(RADDR_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr_en  (reg_wr_en),
        .reg_wr_addr(reg_wr_addr),
        .reg_wr_data(reg_wr_data),
        .reg_rd_addr(reg_rd_addr),
        .missed_set (missed_set),
        .reg_rd_data(reg_rd_data),
        .map_entry  (map_entry),
        .map_word   (map_word),
        .chan_en    (chan_en),
        .missed     (missed_flags)
    );

    trigw_match #(
        .NUM_CH(NUM_CH),
        .ENT_W (ENT_W),
        .WRD_W (WRD_W),
        .PW_AW (PW_AW)
    ) u_match (
        .pw_valid (pw_valid),
        .pw_addr  (pw_addr),
        .pw_be    (pw_be),
        .map_entry(map_entry),
        .map_word (map_word),
        .hit      (hit)
    );

    trigw_queue #(
        .NUM_CH(NUM_CH),
        .ENT_W (ENT_W),
        .CH_W  (CH_W)
    ) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit       (hit),
        .chan_en   (chan_en),
        .map_entry (map_entry),
        .req_ready (req_ready),
        .req_valid (req_valid),
        .req_chan  (req_chan),
        .req_entry (req_entry),
        .pend      (pend_bits),
        .missed_set(missed_set)
    );
endmodule

// File: rtl/trigw_checker.sv
// Module trigw_checker
// Concurrent properties for trigw_top, attached by bind below.
// Assumes internal waiting bits, enables and missed flags are connected.
module trigw_checker #(
    parameter int unsigned NUM_CH  = 8,
    parameter int unsigned CH_W    = 3,
    parameter int unsigned RADDR_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               pw_valid,
    input logic [3:0]         pw_be,
    input logic               req_valid,
    input logic               req_ready,
    input logic [CH_W-1:0]    req_chan,
    input logic [NUM_CH-1:0]  pending,
    input logic [NUM_CH-1:0]  chan_en,
    input logic [NUM_CH-1:0]  missed,
    input logic               reg_wr_en,
    input logic [RADDR_W-1:0] reg_wr_addr,
    input logic [31:0]        reg_wr_data
);
    localparam logic [RADDR_W-1:0] MISS_IDX = RADDR_W'(NUM_CH + 1);

    // R3 and R5: a new request needs a qualified write one cycle earlier.
    a_r5_req_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_valid) |-> $past(pw_valid && (pw_be != 4'b0000)));

    // R8: an offered request is not withdrawn without a handshake.
    a_r8_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> req_valid);

    // R9: presented channel is waiting and no lower channel waits.
    a_r9_lowest_first: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (pending[req_chan] &&
                       ((pending & ~({NUM_CH{1'b1}} << req_chan)) == '0)));

    genvar gk;
    generate
        for (gk = 0; gk < NUM_CH; gk++) begin : g_chk
            // R6: a channel only starts waiting when enabled.
            a_r6_disabled_no_wait: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(pending[gk]) |-> $past(chan_en[gk]));

            // R10: a missed flag drops only on a write-1 clear.
            a_r10_missed_sticky: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(missed[gk]) &&
                 !($past(reg_wr_en) && $past(reg_wr_addr) == MISS_IDX &&
                   $past(reg_wr_data[gk]))) |-> missed[gk]);
        end
    endgenerate
endmodule

bind trigw_top trigw_checker #(
    .NUM_CH (NUM_CH),
    .CH_W   (CH_W),
    .RADDR_W(RADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pw_valid   (pw_valid),
    .pw_be      (pw_be),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_chan   (req_chan),
    .pending    (pend_bits),
    .chan_en    (chan_en),
    .missed     (missed_flags),
    .reg_wr_en  (reg_wr_en),
    .reg_wr_addr(reg_wr_addr),
    .reg_wr_data(reg_wr_data)
);

// File: tb/trigw_top_bench.sv
// Bench for trigw_top: a vector table walked by one loop, then directed
// tests for reset, register layout, collisions, ordering and flag clearing.
module trigw_top_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        pw_valid;
    logic [11:0] pw_addr;
    logic [3:0]  pw_be;
    logic        reg_wr_en;
    logic [3:0]  reg_wr_addr;
    logic [31:0] reg_wr_data;
    logic [3:0]  reg_rd_addr;
    logic [31:0] reg_rd_data;
    logic        req_valid;
    logic        req_ready;
    logic [2:0]  req_chan;
    logic [6:0]  req_entry;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    trigw_top u_trigw_top (
        .clk(clk), .rst_n(rst_n), .pw_valid(pw_valid), .pw_addr(pw_addr),
        .pw_be(pw_be), .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr),
        .reg_wr_data(reg_wr_data), .reg_rd_addr(reg_rd_addr),
        .reg_rd_data(reg_rd_data), .req_valid(req_valid),
        .req_ready(req_ready), .req_chan(req_chan), .req_entry(req_entry)
    );

    typedef struct packed {
        logic [2:0]  ch;
        logic [6:0]  ent;
        logic [2:0]  wd;
        logic [7:0]  en;
        logic [11:0] addr;
        logic [3:0]  be;
        logic        exp_v;
        logic        exp_m;
    } vec_t;

    // ch, entry, word, enable mask, write address, byte enables, expect req, expect missed
    localparam vec_t VECS [7] = '{
        '{3'd2, 7'd5,   3'd3, 8'h04, 12'd172,  4'hF, 1'b1, 1'b0},  // R3
        '{3'd7, 7'd127, 3'd7, 8'h80, 12'd4094, 4'h4, 1'b1, 1'b0},  // R3 offset ignored
        '{3'd0, 7'd10,  3'd1, 8'h01, 12'd328,  4'hF, 1'b0, 1'b0},  // R4 other word
        '{3'd1, 7'd10,  3'd1, 8'h02, 12'd356,  4'hF, 1'b0, 1'b0},  // R4 other entry
        '{3'd3, 7'd20,  3'd0, 8'h08, 12'd640,  4'h0, 1'b0, 1'b0},  // R5 no lanes
        '{3'd4, 7'd33,  3'd6, 8'h00, 12'd1080, 4'h1, 1'b0, 1'b1},  // R6 disabled
        '{3'd0, 7'd0,   3'd0, 8'h01, 12'd0,    4'h8, 1'b1, 1'b0}   // R3 entry 0
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
        reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
        tick();
        reg_wr_en = 1'b0;
    endtask

    task automatic rd_reg(input logic [3:0] a, output logic [31:0] d);
        reg_rd_addr = a;
        #1;
        d = reg_rd_data;
    endtask

    task automatic snoop(input logic [11:0] a, input logic [3:0] be);
        pw_valid = 1'b1; pw_addr = a; pw_be = be;
        tick();
        pw_valid = 1'b0;
    endtask

    task automatic accept;
        req_ready = 1'b1;
        tick();
        req_ready = 1'b0;
    endtask

    function automatic logic [31:0] map_val(input logic [6:0] e, input logic [2:0] w);
        return (32'(e) << 5) | (32'(w) << 2);
    endfunction

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        rst_n = 1'b0; pw_valid = 1'b0; pw_addr = '0; pw_be = '0;
        reg_wr_en = 1'b0; reg_wr_addr = '0; reg_wr_data = '0;
        reg_rd_addr = '0; req_ready = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        check(req_valid == 1'b0, "R1 req_valid", int'(req_valid), 0);
        rd_reg(4'd3, d); check(d == 32'h0, "R1 map3", int'(d), 0);
        rd_reg(4'd8, d); check(d == 32'h0, "R1 enable", int'(d), 0);
        rd_reg(4'd9, d); check(d == 32'h0, "R1 missed", int'(d), 0);

        // R2 register layout readback
        wr_reg(4'd6, 32'hFFFF_FFFF);
        rd_reg(4'd6, d); check(d == 32'h0000_0FFC, "R2 map layout", int'(d), 32'hFFC);
        wr_reg(4'd8, 32'hFFFF_FFFF);
        rd_reg(4'd8, d); check(d == 32'h0000_00FF, "R2 enable width", int'(d), 32'hFF);
        wr_reg(4'd8, 32'h0);
        wr_reg(4'd6, 32'h0);

        // Vector table: R3 R4 R5 R6
        foreach (VECS[i]) begin
            wr_reg(4'd9, 32'hFF);
            wr_reg(4'(VECS[i].ch), map_val(VECS[i].ent, VECS[i].wd));
            wr_reg(4'd8, 32'(VECS[i].en));
            snoop(VECS[i].addr, VECS[i].be);
            check(req_valid == VECS[i].exp_v, $sformatf("R3/R4/R5 vec%0d valid", i),
                  int'(req_valid), int'(VECS[i].exp_v));
            if (VECS[i].exp_v) begin
                check(req_chan == VECS[i].ch, $sformatf("R3 vec%0d chan", i),
                      int'(req_chan), int'(VECS[i].ch));
                check(req_entry == VECS[i].ent, $sformatf("R3 vec%0d entry", i),
                      int'(req_entry), int'(VECS[i].ent));
                accept();
                check(req_valid == 1'b0, $sformatf("R8 vec%0d drained", i), int'(req_valid), 0);
            end
            rd_reg(4'd9, d);
            check(d[VECS[i].ch] == VECS[i].exp_m, $sformatf("R6 vec%0d missed", i),
                  int'(d[VECS[i].ch]), int'(VECS[i].exp_m));
        end

        // R7 and R8: collision while waiting, hold without ready
        wr_reg(4'd9, 32'hFF);
        wr_reg(4'd5, map_val(7'd40, 3'd2));
        wr_reg(4'd8, 32'h20);
        snoop(12'd1288, 4'hF);
        repeat (3) tick();
        check(req_valid == 1'b1 && req_chan == 3'd5, "R8 held request",
              int'({req_valid, req_chan}), 'hD);
        snoop(12'd1288, 4'h3);
        rd_reg(4'd9, d); check(d == 32'h20, "R7 missed on collision", int'(d), 32'h20);
        accept();
        check(req_valid == 1'b0, "R7 no second request", int'(req_valid), 0);
        tick();
        check(req_valid == 1'b0, "R7 still idle", int'(req_valid), 0);

        // R9 lowest first among simultaneous matches
        wr_reg(4'd1, map_val(7'd50, 3'd4));
        wr_reg(4'd3, map_val(7'd50, 3'd4));
        wr_reg(4'd6, map_val(7'd50, 3'd4));
        wr_reg(4'd8, 32'h4A);
        snoop(12'd1616, 4'h1);
        check(req_valid && req_chan == 3'd1, "R9 first chan1", int'(req_chan), 1);
        accept();
        check(req_valid && req_chan == 3'd3, "R9 second chan3", int'(req_chan), 3);
        accept();
        check(req_valid && req_chan == 3'd6 && req_entry == 7'd50, "R9 third chan6",
              int'(req_chan), 6);
        accept();
        check(req_valid == 1'b0, "R9 all drained", int'(req_valid), 0);

        // R10 sticky, write-1-to-clear, set wins over clear
        wr_reg(4'd9, 32'hFF);
        wr_reg(4'd8, 32'h0);
        snoop(12'd1080, 4'hF);
        wr_reg(4'd9, 32'h0);
        rd_reg(4'd9, d); check(d == 32'h10, "R10 sticky on zero write", int'(d), 32'h10);
        wr_reg(4'd9, 32'h10);
        rd_reg(4'd9, d); check(d == 32'h0, "R10 cleared", int'(d), 0);
        pw_valid = 1'b1; pw_addr = 12'd1080; pw_be = 4'h2;
        wr_reg(4'd9, 32'h10);
        pw_valid = 1'b0;
        rd_reg(4'd9, d); check(d == 32'h10, "R10 set wins", int'(d), 32'h10);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule